// File: doc/BRIEF.md
# Clock Switch Ready Timer

This block measures the warm-up interval that must pass after software asks for a move to a multiplied clock source. It watches a register write port and holds two byte-wide registers: a power control register and a shared flag register. Writing a particular bit pattern into the power control register starts a 16-bit settling count and clears a ready bit in the flag register. The count advances only on cycles where a clock-enable tick is high. When enough ticks have been counted, the ready bit is set and the counter stops.

Any other value written to the power control register stops a count that is in progress. Software polls the flag register to learn when the new clock source is ready. The block does not switch clocks. It does not model the multiplier itself, and it gives no meaning to the other flag bits beyond storing them.

Top module: `clk_switch_ready_timer`

## Requirements
- R1: A write to the power register address (default 0x2C) stores the written byte with bits 1 and 0 forced to 1, visible on `pwr_q` after the next clock edge.
- R2: A power register write whose data ANDed with 0xD0 equals 0x90 arms the settling count. On the next edge it clears the ready bit, which is bit 3 of `flag_q`. This happens even if the ready bit was already 1.
- R3: A power register write that does not match the arming pattern cancels a count in progress. No ready bit is set from that count, however many ticks follow.
- R4: The ready bit becomes 1 on the clock edge that counts the 65535th tick after the arming write. Cycles with `tick` low are not counted. Re-arming restarts the count from zero. After completion the counter is idle.
- R5: Once set, the ready bit stays 1 through ticks, non-arming power writes and flag writes, until an arming write clears it.
- R6: Synchronous reset clears `pwr_q` and `flag_q` to 0x00 and leaves the counter idle.
- R7: A write to the flag register address (default 0x2D) stores bits 7:4 and 2:0 of the data. Bit 3 (ready) keeps its previous value.
- R8: Writes to any other address leave both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Clock-enable tick that advances the settling count |
| pwr_q | output | 8 | Current power control register value |
| flag_q | output | 8 | Current flag register value, ready at bit 3 |

## Verification
The arming decode is tried with values that match only under the 0xD0 mask, such as 0x90, 0xB4 and 0x9F, and with values like 0x10, 0x40 and 0xD0 that share some of the mask bits but must cancel. This separates a correct mask compare from a plain bit test. A full-length count with a block of tick-low cycles in the middle, checked one tick before and at the terminal tick, shows whether the tick gating and the exact count are right. A second full-length run after a cancel shows whether the cancel really stops the count. Random writes across the two register addresses and a third address, with arming values mixed in, are compared against a bench model. They show whether the forced bits, the protection of the ready bit and the address decode are right.

// File: rtl/csrt_pkg.sv
`timescale 1ns/1ps
package csrt_pkg;

  typedef enum logic {
    SETTLE_IDLE = 1'b0,
    SETTLE_RUN  = 1'b1
  } settle_state_e;

  // True when the masked value equals the arming pattern.
  function automatic logic pattern_hit(input logic [7:0] value,
                                       input logic [7:0] mask,
                                       input logic [7:0] pattern);
    return (value & mask) == (pattern & mask);
  endfunction

endpackage

// File: rtl/csrt_wr_decode.sv
`timescale 1ns/1ps
module csrt_wr_decode #(
  parameter int unsigned     ADDR_W      = 8,
  parameter int unsigned     DATA_W      = 8,
  parameter logic [ADDR_W-1:0] PWR_ADDR  = 8'h2C,
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 8'h2D,
  parameter logic [DATA_W-1:0] ARM_MASK  = 8'hD0,
  parameter logic [DATA_W-1:0] ARM_PATTERN = 8'h90
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pwr_wr,
  output logic              flag_wr,
  output logic              arm,
  output logic              cancel
);

  logic hit;

  always_comb begin
    hit     = ((wr_data & ARM_MASK) == (ARM_PATTERN & ARM_MASK));
    pwr_wr  = wr_en && (wr_addr == PWR_ADDR);
    flag_wr = wr_en && (wr_addr == FLAG_ADDR);
    arm     = pwr_wr && hit;
    cancel  = pwr_wr && !hit;
  end

endmodule

// File: rtl/csrt_pwr_reg.sv
`timescale 1ns/1ps
module csrt_pwr_reg #(
  parameter int unsigned       DATA_W     = 8,
  parameter logic [DATA_W-1:0] FORCE_ONES = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] q
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (FORCE_ONES[b]) begin : g_forced
      always_ff @(posedge clk) begin
        if (rst)     q[b] <= 1'b0;
        else if (wr) q[b] <= 1'b1;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)     q[b] <= 1'b0;
        else if (wr) q[b] <= data[b];
      end
    end
  end

endmodule

// File: rtl/csrt_settle_cnt.sv
`timescale 1ns/1ps
module csrt_settle_cnt
  import csrt_pkg::*;
#(
  parameter int unsigned SETTLE_TICKS = 65535,
  parameter int unsigned CNT_W        = $clog2(SETTLE_TICKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic cancel,
  input  logic tick,
  output logic busy,
  output logic done
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_TICKS - 1);

  settle_state_e    state;
  logic [CNT_W-1:0] cnt;
  logic             advance;

  always_comb begin
    advance = (state == SETTLE_RUN) && tick && !arm && !cancel;
    done    = advance && (cnt == LAST);
    busy    = (state == SETTLE_RUN);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SETTLE_IDLE;
      cnt   <= '0;
    end else if (arm) begin
      state <= SETTLE_RUN;
      cnt   <= '0;
    end else if (cancel) begin
      state <= SETTLE_IDLE;
      cnt   <= '0;
    end else if (done) begin
      state <= SETTLE_IDLE;
      cnt   <= '0;
    end else if (advance) begin
      cnt   <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/csrt_flag_reg.sv
`timescale 1ns/1ps
module csrt_flag_reg #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned READY_BIT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [DATA_W-1:0] data,
  input  logic              ready_clr,
  input  logic              ready_set,
  output logic [DATA_W-1:0] q
);

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b == READY_BIT) begin : g_ready
      always_ff @(posedge clk) begin
        if (rst)            q[b] <= 1'b0;
        else if (ready_clr) q[b] <= 1'b0;
        else if (ready_set) q[b] <= 1'b1;
      end
    end else begin : g_sw
      always_ff @(posedge clk) begin
        if (rst)     q[b] <= 1'b0;
        else if (wr) q[b] <= data[b];
      end
    end
  end

endmodule

// File: rtl/clk_switch_ready_timer.sv
`timescale 1ns/1ps
module clk_switch_ready_timer #(
  parameter int unsigned       ADDR_W       = 8,
  parameter int unsigned       DATA_W       = 8,
  parameter logic [ADDR_W-1:0] PWR_ADDR     = 8'h2C,
  parameter logic [ADDR_W-1:0] FLAG_ADDR    = 8'h2D,
  parameter logic [DATA_W-1:0] FORCE_ONES   = 8'h03,
  parameter logic [DATA_W-1:0] ARM_MASK     = 8'hD0,
  parameter logic [DATA_W-1:0] ARM_PATTERN  = 8'h90,
  parameter int unsigned       READY_BIT    = 3,
  parameter int unsigned       SETTLE_TICKS = 65535
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tick,
  output logic [DATA_W-1:0] pwr_q,
  output logic [DATA_W-1:0] flag_q
);

  localparam int unsigned CNT_W = $clog2(SETTLE_TICKS + 1);

  logic pwr_wr;
  logic flag_wr;
  logic arm;
  logic cancel;
  logic settle_busy;
  logic settle_done;

  csrt_wr_decode #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PWR_ADDR   (PWR_ADDR),
    .FLAG_ADDR  (FLAG_ADDR),
    .ARM_MASK   (ARM_MASK),
    .ARM_PATTERN(ARM_PATTERN)
  ) u_decode (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .pwr_wr (pwr_wr),
    .flag_wr(flag_wr),
    .arm    (arm),
    .cancel (cancel)
  );

  csrt_pwr_reg #(
    .DATA_W    (DATA_W),
    .FORCE_ONES(FORCE_ONES)
  ) u_pwr (
    .clk (clk),
    .rst (rst),
    .wr  (pwr_wr),
    .data(wr_data),
    .q   (pwr_q)
  );

  csrt_settle_cnt #(
    .SETTLE_TICKS(SETTLE_TICKS),
    .CNT_W       (CNT_W)
  ) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .arm   (arm),
    .cancel(cancel),
    .tick  (tick),
    .busy  (settle_busy),
    .done  (settle_done)
  );

  csrt_flag_reg #(
    .DATA_W   (DATA_W),
    .READY_BIT(READY_BIT)
  ) u_flag (
    .clk      (clk),
    .rst      (rst),
    .wr       (flag_wr),
    .data     (wr_data),
    .ready_clr(arm),
    .ready_set(settle_done),
    .q        (flag_q)
  );

endmodule

// File: rtl/csrt_checker.sv
`timescale 1ns/1ps
module csrt_checker #(
  parameter int unsigned       ADDR_W      = 8,
  parameter int unsigned       DATA_W      = 8,
  parameter logic [ADDR_W-1:0] PWR_ADDR    = 8'h2C,
  parameter logic [ADDR_W-1:0] FLAG_ADDR   = 8'h2D,
  parameter logic [DATA_W-1:0] FORCE_ONES  = 8'h03,
  parameter logic [DATA_W-1:0] ARM_MASK    = 8'hD0,
  parameter logic [DATA_W-1:0] ARM_PATTERN = 8'h90,
  parameter int unsigned       READY_BIT   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              tick,
  input logic [DATA_W-1:0] pwr_q,
  input logic [DATA_W-1:0] flag_q,
  input logic              settle_busy
);

  logic to_pwr, to_flag, to_other, arming;

  always_comb begin
    to_pwr   = wr_en && (wr_addr == PWR_ADDR);
    to_flag  = wr_en && (wr_addr == FLAG_ADDR);
    to_other = wr_en && !to_pwr && !to_flag;
    arming   = to_pwr && ((wr_data & ARM_MASK) == (ARM_PATTERN & ARM_MASK));
  end

  AST_PWR_FORCED_ONES: assert property (@(posedge clk) disable iff (rst)
    to_pwr |=> (pwr_q == ($past(wr_data) | FORCE_ONES))); // R1
  AST_ARM_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
    arming |=> (!flag_q[READY_BIT] && settle_busy)); // R2
  AST_CANCEL_IDLES: assert property (@(posedge clk) disable iff (rst)
    (to_pwr && !arming) |=> !settle_busy); // R3
  AST_READY_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[READY_BIT]) |-> ($past(tick) && $past(settle_busy))); // R4
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (flag_q[READY_BIT] && !arming) |=> flag_q[READY_BIT]); // R5
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> ((pwr_q == '0) && (flag_q == '0) && !settle_busy)); // R6
  AST_FLAG_WRITE_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
    (to_flag && !settle_busy) |=> $stable(flag_q[READY_BIT])); // R7
  AST_OTHER_ADDR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    to_other |=> $stable(pwr_q)); // R8

endmodule

bind clk_switch_ready_timer csrt_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .PWR_ADDR   (PWR_ADDR),
  .FLAG_ADDR  (FLAG_ADDR),
  .FORCE_ONES (FORCE_ONES),
  .ARM_MASK   (ARM_MASK),
  .ARM_PATTERN(ARM_PATTERN),
  .READY_BIT  (READY_BIT)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .tick       (tick),
  .pwr_q      (pwr_q),
  .flag_q     (flag_q),
  .settle_busy(settle_busy)
);

// File: tb/clk_switch_ready_timer_tb.sv
`timescale 1ns/1ps
module clk_switch_ready_timer_tb_top;

  localparam int unsigned SETTLE = 65535;
  localparam logic [7:0]  PWR_A  = 8'h2C;
  localparam logic [7:0]  FLAG_A = 8'h2D;
  localparam logic [7:0]  OTHER_A = 8'h30;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [7:0] pwr_q;
  logic [7:0] flag_q;

  always #2 clk = ~clk;

  clk_switch_ready_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tick(tick), .pwr_q(pwr_q), .flag_q(flag_q)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  bit   finished = 0;
  logic [7:0] m_pwr = '0;
  logic [7:0] m_flag = '0;
  bit   m_busy = 0;
  int   m_cnt = 0;

  function automatic bit is_arm(input logic [7:0] d);
    return (d & 8'hD0) == 8'h90;
  endfunction

  function automatic logic [7:0] pwr_expect(input logic [7:0] d);
    return d | 8'h03;
  endfunction

  function automatic logic [7:0] flag_expect(input logic [7:0] d, input logic [7:0] old);
    return (d & 8'hF7) | (old & 8'h08);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, update the model at posedge, return 1 ns later.
  task automatic step(input bit we, input logic [7:0] a, input logic [7:0] d, input bit tk);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; tick = tk;
    @(posedge clk);
    if (we && a == PWR_A) begin
      m_pwr = pwr_expect(d);
      if (is_arm(d)) begin m_busy = 1; m_cnt = 0; m_flag[3] = 1'b0; end
      else m_busy = 0;
    end else begin
      if (we && a == FLAG_A) m_flag = flag_expect(d, m_flag);
      if (m_busy && tk) begin
        m_cnt++;
        if (m_cnt == SETTLE) begin m_busy = 0; m_flag[3] = 1'b1; end
      end
    end
    #1;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 8'h00, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R6 pwr reset", pwr_q, 8'h00);
    chk("R6 flag reset", flag_q, 8'h00);

    step(1, PWR_A, 8'h00, 0);  chk("R1 zero data", pwr_q, 8'h03);
    step(1, PWR_A, 8'hFC, 0);  chk("R1 high data", pwr_q, 8'hFF);
    step(1, OTHER_A, 8'hAA, 1);
    chk("R8 pwr kept", pwr_q, 8'hFF);
    chk("R8 flag kept", flag_q, 8'h00);
    step(1, FLAG_A, 8'hFF, 0); chk("R7 ready kept low", flag_q, 8'hF7);

    // Cancel path: arm, count a little, cancel, then a full window.
    step(1, PWR_A, 8'h90, 0);
    chk("R1 arm value", pwr_q, 8'h93);
    chk("R2 ready cleared", flag_q, 8'hF7);
    ticks(100);
    step(1, PWR_A, 8'h10, 1);  chk("R3 cancel value", pwr_q, 8'h13);
    ticks(SETTLE + 5);
    chk("R3 no ready after cancel", flag_q, 8'hF7);

    // Re-arm restarts; gated ticks; exact terminal tick.
    step(1, PWR_A, 8'hB4, 0);  chk("R1 arm B4", pwr_q, 8'hB7);
    ticks(300);
    step(1, PWR_A, 8'h9F, 1);  chk("R2 re-arm", pwr_q, 8'h9F);
    for (int i = 0; i < 200; i++) step(0, 8'h00, 8'h00, 0);
    ticks(SETTLE - 1);
    chk("R4 one tick short", flag_q, 8'hF7);
    ticks(1);
    chk("R4 terminal tick", flag_q, 8'hFF);

    // Hold behaviour.
    step(1, PWR_A, 8'h40, 1);  chk("R5 non-arm write", flag_q, 8'hFF);
    step(1, FLAG_A, 8'h00, 1); chk("R7 ready kept high", flag_q, 8'h08);
    ticks(50);                 chk("R5 ticks keep ready", flag_q, 8'h08);
    step(1, PWR_A, 8'hD0, 0);  chk("R5 D0 is not arming", flag_q, 8'h08);
    step(1, PWR_A, 8'h91, 0);  chk("R2 arm clears set ready", flag_q, 8'h00);

    // Constrained random against the bench model.
    void'($urandom(32'h5EED_C10C));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a, d;
      int sel;
      bit we;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? PWR_A : (sel < 8) ? FLAG_A : OTHER_A;
      d = 8'($urandom);
      if ($urandom_range(0, 5) == 0) d = (d & 8'h2F) | 8'h90;
      we = ($urandom_range(0, 1) == 1);
      step(we, a, d, $urandom_range(0, 1) == 1);
      if (we) begin
        chk((a == PWR_A) ? "R1 random pwr" : (a == FLAG_A) ? "R7 random pwr" : "R8 random pwr",
            pwr_q, m_pwr);
        chk((a == FLAG_A) ? "R7 random flag" : (a == PWR_A) ? "R2 random flag" : "R8 random flag",
            flag_q, m_flag);
      end
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule